// File: doc/BRIEF.md
# Pin Event Flag and Request Detector

This block watches a bank of already-filtered digital inputs and raises a sticky status flag for each pin when the condition chosen by that pin's 4-bit event code occurs. Each code picks a trigger and a destination. The trigger can be a rising edge, a falling edge, either edge, a low level or a high level. The destination can be the interrupt line or the DMA request line. The event codes come from a control register bank held elsewhere in the chip. The DMA arbiter that serves the request is outside this block.

Software sees the flags as one status word or one pin at a time through a read index. It clears flags by writing ones to the bits it wants cleared. A completion pulse from the DMA engine clears every flag whose pin is routed to DMA. Level-triggered pins keep their flag asserted for as long as the level persists, so a clear during the active level has no visible effect. When a set and a clear fall in the same cycle, the set takes priority.

Top module: `pin_evt_detector`

## Requirements
- R1: While reset is asserted, `status`, `irq` and `dma_req` are all zero.
- R2: Code 4'h1 (DMA) and code 4'h9 (interrupt) set the pin's flag at the first clock edge that samples the pin high after a clock edge that sampled it low. The flag stays set after the pin returns low.
- R3: Code 4'h2 (DMA) and code 4'hA (interrupt) set the flag on a high-to-low change of the sampled pin. A rising change leaves the flag clear.
- R4: Code 4'h3 (DMA) and code 4'hB (interrupt) set the flag on either change of the sampled pin.
- R5: Code 4'h8 sets the flag at every clock edge that samples the pin low, and code 4'hC does the same for a pin sampled high. A write-1 clear during the active level leaves the flag set. A clear taken after the level ends leaves the flag clear.
- R6: Code 4'h0 and the unused codes 4'h4–4'h7 and 4'hD–4'hF never set a flag, whatever the pin does.
- R7: A cycle with `clr_wr` high clears each flag whose `clr_mask` bit is 1 and leaves the other flags unchanged. A mask of all ones clears every flag.
- R8: A cycle with `dma_done` high clears the flags of pins with codes 4'h1–4'h3 and leaves the flags of interrupt-routed pins set.
- R9: If a set condition and a clear (from `clr_wr` or `dma_done`) reach the same flag in the same cycle, the flag ends set.
- R10: `irq` is the OR of the flags of pins whose current code is 4'h8–4'hC. `dma_req` is the OR of the flags of pins whose current code is 4'h1–4'h3. Both follow the flags with no added delay.
- R11: `rd_flag` equals bit `rd_idx` of `status`, combinationally.
- R12: The first clock edge after reset release records the pins and never reports an edge, even when a pin is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Filtered, synchronised pin levels |
| cfg_code | input | NUM_PINS*4 | Event code per pin; pin i at bits [4i+3:4i] |
| clr_wr | input | 1 | Write strobe for write-1 clear |
| clr_mask | input | NUM_PINS | Bits set to 1 clear the matching flags |
| dma_done | input | 1 | DMA transfer complete; clears DMA-routed flags |
| rd_idx | input | IDX_W | Pin selected for single-flag read |
| status | output | NUM_PINS | Flag of every pin |
| irq | output | 1 | Combined interrupt request |
| dma_req | output | 1 | Combined DMA request |
| rd_flag | output | 1 | Flag of the pin picked by rd_idx |

## Verification
A pin change, clear strobe or DMA-done pulse applied between clock edges shows up in `status` right after the next rising edge, one register stage. `irq`, `dma_req` and `rd_flag` are combinational on top of that, so they move in the same cycle as the flags. The bench drives every input at the falling edge and compares outputs at the following falling edge, exactly one rising edge later. For the read index it compares after a short settling delay with no clock edge in between. The assertions use the same one-cycle offset through `$past` at depth one, or depth two where an edge depends on the previous sample.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

   localparam int CODE_W = 4;

   localparam logic [CODE_W-1:0] EVC_OFF      = 4'h0;
   localparam logic [CODE_W-1:0] EVC_DMA_RISE = 4'h1;
   localparam logic [CODE_W-1:0] EVC_DMA_FALL = 4'h2;
   localparam logic [CODE_W-1:0] EVC_DMA_BOTH = 4'h3;
   localparam logic [CODE_W-1:0] EVC_IRQ_LOW  = 4'h8;
   localparam logic [CODE_W-1:0] EVC_IRQ_RISE = 4'h9;
   localparam logic [CODE_W-1:0] EVC_IRQ_FALL = 4'hA;
   localparam logic [CODE_W-1:0] EVC_IRQ_BOTH = 4'hB;
   localparam logic [CODE_W-1:0] EVC_IRQ_HIGH = 4'hC;

   typedef struct packed {
      logic to_dma;
      logic to_irq;
      logic on_rise;
      logic on_fall;
      logic on_low;
      logic on_high;
   } ev_sel_t;

   function automatic ev_sel_t decode_code(input logic [CODE_W-1:0] code);
      ev_sel_t s;
      s = '0;
      unique case (code)
         EVC_DMA_RISE: begin s.to_dma = 1'b1; s.on_rise = 1'b1; end
         EVC_DMA_FALL: begin s.to_dma = 1'b1; s.on_fall = 1'b1; end
         EVC_DMA_BOTH: begin s.to_dma = 1'b1; s.on_rise = 1'b1; s.on_fall = 1'b1; end
         EVC_IRQ_LOW:  begin s.to_irq = 1'b1; s.on_low  = 1'b1; end
         EVC_IRQ_RISE: begin s.to_irq = 1'b1; s.on_rise = 1'b1; end
         EVC_IRQ_FALL: begin s.to_irq = 1'b1; s.on_fall = 1'b1; end
         EVC_IRQ_BOTH: begin s.to_irq = 1'b1; s.on_rise = 1'b1; s.on_fall = 1'b1; end
         EVC_IRQ_HIGH: begin s.to_irq = 1'b1; s.on_high = 1'b1; end
         default:      s = '0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/pin_evt_decode.sv
module pin_evt_decode
   import pin_evt_pkg::*;
(
   input  logic [CODE_W-1:0] code,
   output ev_sel_t           sel
);

   always_comb sel = decode_code(code);

endmodule

// File: rtl/pin_evt_sampler.sv
module pin_evt_sampler #(
   parameter int NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] rise,
   output logic [NUM_PINS-1:0] fall
);

   logic [NUM_PINS-1:0] prev_q;
   logic                primed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '0;
         primed_q <= 1'b0;
      end else begin
         prev_q   <= pin_in;
         primed_q <= 1'b1;
      end
   end

   // No edge is reported until the registered copy holds a real sample.
   assign rise = primed_q ? (pin_in & ~prev_q) : '0;
   assign fall = primed_q ? (~pin_in & prev_q) : '0;

endmodule

// File: rtl/pin_evt_flag.sv
module pin_evt_flag
   import pin_evt_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  ev_sel_t sel,
   input  logic    pin,
   input  logic    rise,
   input  logic    fall,
   input  logic    clr_w1,
   input  logic    dma_done,
   output logic    flag_q
);

   logic set_ev;
   logic clr_ev;

   assign set_ev = (sel.on_rise & rise) | (sel.on_fall & fall) |
                   (sel.on_low & ~pin)  | (sel.on_high & pin);
   assign clr_ev = clr_w1 | (dma_done & sel.to_dma);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (set_ev) flag_q <= 1'b1;   // set has priority over clear
      else if (clr_ev) flag_q <= 1'b0;
   end

endmodule

// File: rtl/pin_evt_detector.sv
module pin_evt_detector
   import pin_evt_pkg::*;
#(
   parameter int NUM_PINS = 32,
   localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PINS-1:0]        pin_in,
   input  logic [NUM_PINS*CODE_W-1:0] cfg_code,
   input  logic                       clr_wr,
   input  logic [NUM_PINS-1:0]        clr_mask,
   input  logic                       dma_done,
   input  logic [IDX_W-1:0]           rd_idx,
   output logic [NUM_PINS-1:0]        status,
   output logic                       irq,
   output logic                       dma_req,
   output logic                       rd_flag
);

   generate
      if (NUM_PINS < 2 || NUM_PINS > 32) begin : g_bad_width
         $error("pin_evt_detector: NUM_PINS must lie in 2..32");
      end
   endgenerate

   logic [NUM_PINS-1:0] rise;
   logic [NUM_PINS-1:0] fall;
   logic [NUM_PINS-1:0] irq_vec;
   logic [NUM_PINS-1:0] dma_vec;

   pin_evt_sampler #(.NUM_PINS(NUM_PINS)) sampler_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_in (pin_in),
      .rise   (rise),
      .fall   (fall)
   );

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         ev_sel_t sel;

         pin_evt_decode decode_i (
            .code (cfg_code[i*CODE_W +: CODE_W]),
            .sel  (sel)
         );

         pin_evt_flag flag_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (sel),
            .pin      (pin_in[i]),
            .rise     (rise[i]),
            .fall     (fall[i]),
            .clr_w1   (clr_wr & clr_mask[i]),
            .dma_done (dma_done),
            .flag_q   (status[i])
         );

         assign irq_vec[i] = status[i] & sel.to_irq;
         assign dma_vec[i] = status[i] & sel.to_dma;
      end
   endgenerate

   assign irq     = |irq_vec;
   assign dma_req = |dma_vec;
   assign rd_flag = status[rd_idx];

endmodule

// File: rtl/pin_evt_detector_chk.sv
module pin_evt_detector_chk
   import pin_evt_pkg::*;
#(
   parameter int NUM_PINS = 32,
   localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_PINS-1:0]        pin_in,
   input logic [NUM_PINS*CODE_W-1:0] cfg_code,
   input logic                       clr_wr,
   input logic [NUM_PINS-1:0]        clr_mask,
   input logic                       dma_done,
   input logic [IDX_W-1:0]           rd_idx,
   input logic [NUM_PINS-1:0]        status,
   input logic                       irq,
   input logic                       dma_req,
   input logic                       rd_flag
);

   logic [NUM_PINS-1:0] irq_pins;
   logic [NUM_PINS-1:0] dma_pins;
   logic [NUM_PINS-1:0] live_code;

   always_comb begin
      for (int k = 0; k < NUM_PINS; k++) begin
         logic [CODE_W-1:0] c;
         c = cfg_code[k*CODE_W +: CODE_W];
         irq_pins[k]  = (c >= 4'h8) && (c <= 4'hC);
         dma_pins[k]  = (c >= 4'h1) && (c <= 4'h3);
         live_code[k] = irq_pins[k] | dma_pins[k];
      end
   end

   // R1
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (status == '0 && !irq && !dma_req));

   // R10
   a_r10_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
      irq == |(status & irq_pins));
   a_r10_dma_or: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req == |(status & dma_pins));

   // R11
   a_r11_read_sel: assert property (@(posedge clk) disable iff (!rst_n)
      rd_flag == status[rd_idx]);

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
         // R6
         a_r6_only_live_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !$past(status[i])) |-> $past(live_code[i]));
         // R5
         a_r5_low_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
            $past(cfg_code[i*CODE_W +: CODE_W] == 4'h8 && !pin_in[i]) |-> status[i]);
         // R7
         a_r7_clear_off_pin: assert property (@(posedge clk) disable iff (!rst_n)
            $past(clr_wr && clr_mask[i] && cfg_code[i*CODE_W +: CODE_W] == 4'h0) |-> !status[i]);
         // R8
         a_r8_dma_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(dma_done && dma_pins[i]) && $past(pin_in[i], 1) == $past(pin_in[i], 2))
            |-> !status[i]);
      end
   endgenerate

endmodule

bind pin_evt_detector pin_evt_detector_chk #(.NUM_PINS(NUM_PINS)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .pin_in   (pin_in),
   .cfg_code (cfg_code),
   .clr_wr   (clr_wr),
   .clr_mask (clr_mask),
   .dma_done (dma_done),
   .rd_idx   (rd_idx),
   .status   (status),
   .irq      (irq),
   .dma_req  (dma_req),
   .rd_flag  (rd_flag)
);

// File: tb/pin_evt_detector_tb_top.sv
module pin_evt_detector_tb_top;

   localparam int N = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pin = '0;
   logic [3:0]    code_a [N];
   logic [N*4-1:0] cfg_code;
   logic          clr_wr = 1'b0;
   logic [N-1:0]  clr_mask = '0;
   logic          dma_done = 1'b0;
   logic [4:0]    rd_idx = '0;
   logic [N-1:0]  status;
   logic          irq, dma_req, rd_flag;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < N; i++) cfg_code[i*4 +: 4] = code_a[i];
   end

   pin_evt_detector #(.NUM_PINS(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .pin_in(pin), .cfg_code(cfg_code),
      .clr_wr(clr_wr), .clr_mask(clr_mask), .dma_done(dma_done),
      .rd_idx(rd_idx), .status(status), .irq(irq), .dma_req(dma_req),
      .rd_flag(rd_flag)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      for (int i = 0; i < N; i++) code_a[i] = 4'h0;
      pin = '0; dma_done = 1'b0;
      step();
      clr_wr = 1'b1; clr_mask = '1;
      step();
      clr_wr = 1'b0; clr_mask = '0;
      step();
   endtask

   task automatic t_reset();
      for (int i = 0; i < N; i++) code_a[i] = 4'h0;
      code_a[0] = 4'h9;
      pin[0] = 1'b1;
      step(); step();
      chk("R1 status in reset", status, 32'h0);
      chk("R1 irq in reset", {31'b0, irq}, 32'h0);
      chk("R1 dma_req in reset", {31'b0, dma_req}, 32'h0);
      rst_n = 1'b1;
      step();
      chk("R12 no edge on first sample", status, 32'h0);
      step();
      chk("R12 still no edge", status, 32'h0);
   endtask

   task automatic t_rise();
      idle();
      code_a[0] = 4'h9; code_a[1] = 4'h1; code_a[4] = 4'hA;
      step();
      pin[0] = 1'b1; pin[1] = 1'b1; pin[4] = 1'b1;
      step();
      chk("R2 rising edge flags, R3 fall code ignores rise", status, 32'h3);
      chk("R10 irq from rise", {31'b0, irq}, 32'h1);
      chk("R10 dma_req from rise", {31'b0, dma_req}, 32'h1);
      pin = '0;
      step();
      chk("R2 flags held after low, R3 fall sets pin4", status, 32'h13);
   endtask

   task automatic t_fall();
      idle();
      code_a[2] = 4'hA; code_a[3] = 4'h2; code_a[5] = 4'h9;
      step();
      pin[2] = 1'b1; pin[3] = 1'b1; pin[5] = 1'b1;
      step();
      chk("R3 rise leaves fall-coded pins clear", status, 32'h20);
      pin = '0;
      step();
      chk("R3 falling edge flags", status, 32'h2C);
   endtask

   task automatic t_either();
      idle();
      code_a[5] = 4'hB; code_a[6] = 4'h3;
      step();
      pin[5] = 1'b1; pin[6] = 1'b1;
      step();
      chk("R4 either code on rise", status, 32'h60);
      clr_wr = 1'b1; clr_mask = 32'h60;
      step();
      clr_wr = 1'b0; clr_mask = '0;
      chk("R7 cleared before fall", status, 32'h0);
      pin = '0;
      step();
      chk("R4 either code on fall", status, 32'h60);
   endtask

   task automatic t_level();
      idle();
      code_a[7] = 4'h8;
      step();
      chk("R5 low level sets", status, 32'h80);
      chk("R10 irq from level", {31'b0, irq}, 32'h1);
      clr_wr = 1'b1; clr_mask = 32'h80;
      step();
      chk("R5 low level re-asserts after clear", status, 32'h80);
      pin[7] = 1'b1;
      step();
      clr_wr = 1'b0; clr_mask = '0;
      chk("R5 clear after level ends", status, 32'h0);
      code_a[8] = 4'hC; pin[8] = 1'b1;
      step();
      chk("R5 high level sets", status, 32'h100);
      pin[8] = 1'b0;
      step();
      chk("R5 high flag sticky", status, 32'h100);
      clr_wr = 1'b1; clr_mask = 32'h100;
      step();
      clr_wr = 1'b0; clr_mask = '0;
      chk("R5 high flag cleared after level ends", status, 32'h0);
   endtask

   task automatic t_disabled();
      logic [3:0] dead [8];
      dead = '{4'h0, 4'h4, 4'h5, 4'h6, 4'h7, 4'hD, 4'hE, 4'hF};
      idle();
      for (int i = 0; i < 8; i++) code_a[9+i] = dead[i];
      step();
      chk("R6 disabled idle", status, 32'h0);
      pin[16:9] = 8'hFF;
      step(); step();
      chk("R6 disabled rise/high", status, 32'h0);
      pin[16:9] = 8'h00;
      step(); step();
      chk("R6 disabled fall/low", status, 32'h0);
      chk("R6 no irq", {31'b0, irq}, 32'h0);
      chk("R6 no dma_req", {31'b0, dma_req}, 32'h0);
   endtask

   task automatic t_w1c();
      idle();
      code_a[0] = 4'h9; code_a[3] = 4'h9; code_a[10] = 4'hB; code_a[31] = 4'h1;
      step();
      pin[0] = 1'b1; pin[3] = 1'b1; pin[10] = 1'b1; pin[31] = 1'b1;
      step();
      chk("R7 setup flags", status, 32'h8000_0409);
      clr_wr = 1'b1; clr_mask = 32'h8000_0001;
      step();
      clr_wr = 1'b0; clr_mask = '0;
      chk("R7 partial clear", status, 32'h0000_0408);
      clr_wr = 1'b1; clr_mask = '1;
      step();
      clr_wr = 1'b0; clr_mask = '0;
      chk("R7 all-ones clear", status, 32'h0);
   endtask

   task automatic t_dma();
      idle();
      code_a[0] = 4'h1; code_a[1] = 4'h9; code_a[2] = 4'h2;
      step();
      pin[0] = 1'b1; pin[1] = 1'b1; pin[2] = 1'b1;
      step();
      pin[2] = 1'b0;
      step();
      chk("R8 setup flags", status, 32'h7);
      dma_done = 1'b1;
      step();
      dma_done = 1'b0;
      chk("R8 dma_done clears dma pins only", status, 32'h2);
      chk("R10 dma_req drops", {31'b0, dma_req}, 32'h0);
      chk("R10 irq stays", {31'b0, irq}, 32'h1);
   endtask

   task automatic t_set_wins();
      idle();
      code_a[0] = 4'h9; code_a[1] = 4'h1;
      step();
      pin[0] = 1'b1; clr_wr = 1'b1; clr_mask = 32'h1;
      step();
      clr_wr = 1'b0; clr_mask = '0;
      chk("R9 edge beats write-1 clear", status, 32'h1);
      pin[1] = 1'b1; dma_done = 1'b1;
      step();
      dma_done = 1'b0;
      chk("R9 edge beats dma_done", status, 32'h3);
   endtask

   task automatic t_read();
      for (int i = 0; i < N; i++) begin
         rd_idx = 5'(i);
         #1;
         chk("R11 per-pin read", {31'b0, rd_flag}, {31'b0, (i < 2) ? 1'b1 : 1'b0});
      end
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < N; i++) code_a[i] = 4'h0;
      @(negedge clk);
      t_reset();
      t_rise();
      t_fall();
      t_either();
      t_level();
      t_disabled();
      t_w1c();
      t_dma();
      t_set_wins();
      t_read();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule